// File: doc/BRIEF.md
# Longword-to-Word Access Splitter

This bridge sits between a CPU-side port and a register file that is only 16 bits wide. The CPU port issues byte, word or longword accesses. Every cycle on the peripheral side is stretched to a fixed length of `BUS_CYCLES` clocks, which is three by default.

A byte or word access becomes a single peripheral cycle. A longword access becomes two peripheral cycles that run back to back. The upper half goes first, at the word with address bit 1 clear. The lower half follows at the word with address bit 1 set. During both halves of a longword the bridge raises a lock output, so that the system arbiter cannot place another master's cycle between them. Reads and writes follow the same rules. For a longword read, the upper half is held in a register and joined to the lower half before the result is returned.

The CPU holds `cpuReq` and its request fields until it sees a one-clock `cpuReady` pulse. The request is captured when it is accepted. Changes to the request fields after that point have no effect.

Top module: `word_split_bridge`

## Requirements
- R1: After reset, `cpuReady`, `perSel` and `busLock` are all low.
- R2: Each peripheral cycle keeps `perSel` high for exactly `BUS_CYCLES` consecutive clocks (3 by default), with `perAddr` and `perWrite` stable throughout.
- R3: A byte access (`cpuSize` = 00) or a word access (`cpuSize` = 01) produces exactly one peripheral cycle. `cpuReady` is high in the clock after that cycle ends, which is 4 clocks after acceptance by default.
- R4: A longword access (`cpuSize` = 10) produces two peripheral cycles with no idle clock between them, so `perSel` is high for 6 consecutive clocks. The first cycle uses the address with bit 1 = 0 and the second uses bit 1 = 1. `cpuReady` follows 7 clocks after acceptance.
- R5: `busLock` is high on every clock of both halves of a longword. It is low throughout byte and word accesses and whenever `perSel` is low.
- R6: Write data is driven as follows: for a longword, `cpuWdata[31:16]` in the first half and `cpuWdata[15:0]` in the second; for a byte or word access, `cpuWdata[15:0]`.
- R7: A longword read returns {first-half data, second-half data}. A byte or word read returns the 16 bits zero-extended. The result appears on `cpuRdata` when `cpuReady` is high.
- R8: `cpuReady` is a one-clock pulse. Changes to `cpuAddr` or `cpuWdata` after a request is accepted have no effect on that transfer.
- R9: Reads and writes of the same size have identical timing and lock behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Request, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | 00 byte, 01 word, 10 longword |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | One-clock completion pulse |
| cpuRdata | output | 32 | Assembled read data |
| perSel | output | 1 | Peripheral cycle active |
| perWrite | output | 1 | Peripheral cycle direction |
| perAddr | output | ADDR_W | Word address on the peripheral side |
| perWdata | output | 16 | Peripheral write data |
| perRdata | input | 16 | Peripheral read data, sampled on the last clock of a cycle |
| busLock | output | 1 | Arbiter hold during a longword |

## Verification
Two events can fall on the same clock edge: the end of the first half, where the upper read data is captured, and the start of the second half, where the address switches and the lock must stay up. The bench provokes this with longword reads and writes against a model register file. It judges the result by checking that `perSel` never drops between the halves, that the lock count equals the select count, and that the returned word holds both halves in the right order. A request field that changes in the middle of a longword checks that the captured request alone drives the second half.

// File: rtl/word_split_pkg.sv
package word_split_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } accSize_e;

  typedef struct packed {
    logic load;    // capture the CPU request
    logic capHi;   // capture upper half of read data
    logic capOut;  // final read data is on the peripheral bus
    logic half;    // 0 = upper (first) half, 1 = lower (second) half
    logic isLong;  // transfer is a longword
  } strobes_t;
endpackage

// File: rtl/split_ctrl.sv
module split_ctrl
  import word_split_pkg::*;
#(
  parameter int BUS_CYCLES = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuReq,
  input  logic [1:0] cpuSize,
  output strobes_t strb,
  output logic     perSel,
  output logic     busLock,
  output logic     cpuReady
);
  localparam int CW = $clog2(BUS_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUS_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  state_e        state;
  logic [CW-1:0] tick;
  logic          half;
  logic          isLong;
  logic          lastTick;

  assign lastTick = (state == ST_RUN) && (tick == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tick   <= '0;
      half   <= 1'b0;
      isLong <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (cpuReq) begin
          state  <= ST_RUN;
          tick   <= '0;
          half   <= 1'b0;
          isLong <= (cpuSize == SZ_LONG);
        end
        ST_RUN: begin
          if (lastTick) begin
            tick <= '0;
            if (isLong && !half) half <= 1'b1;
            else                 state <= ST_DONE;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load   = (state == ST_IDLE) && cpuReq;
    strb.capHi  = lastTick && isLong && !half;
    strb.capOut = lastTick && (!isLong || half);
    strb.half   = half;
    strb.isLong = isLong;
  end

  assign perSel   = (state == ST_RUN);
  assign busLock  = (state == ST_RUN) && isLong;
  assign cpuReady = (state == ST_DONE);
endmodule

// File: rtl/split_datapath.sv
module split_datapath
  import word_split_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [2*HALF_W-1:0] cpuWdata,
  input  logic [HALF_W-1:0] perRdata,
  output logic              perWrite,
  output logic [ADDR_W-1:0] perAddr,
  output logic [HALF_W-1:0] perWdata,
  output logic [2*HALF_W-1:0] cpuRdata
);
  localparam int FULL_W = 2 * HALF_W;

  logic [ADDR_W-1:0] addrQ;
  logic [FULL_W-1:0] wdataQ;
  logic              writeQ;
  logic [HALF_W-1:0] hiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      writeQ   <= 1'b0;
      hiQ      <= '0;
      cpuRdata <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= cpuAddr;
        wdataQ <= cpuWdata;
        writeQ <= cpuWrite;
      end
      if (strb.capHi) hiQ <= perRdata;
      if (strb.capOut)
        cpuRdata <= strb.isLong ? {hiQ, perRdata} : {{HALF_W{1'b0}}, perRdata};
    end
  end

  always_comb begin
    if (strb.isLong) perAddr = {addrQ[ADDR_W-1:2], strb.half, 1'b0};
    else             perAddr = {addrQ[ADDR_W-1:1], 1'b0};
    perWdata = (strb.isLong && !strb.half) ? wdataQ[FULL_W-1:HALF_W]
                                           : wdataQ[HALF_W-1:0];
  end

  assign perWrite = writeQ;
endmodule

// File: rtl/word_split_bridge.sv
module word_split_bridge
  import word_split_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BUS_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [1:0]        cpuSize,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic              cpuReady,
  output logic [31:0]       cpuRdata,
  output logic              perSel,
  output logic              perWrite,
  output logic [ADDR_W-1:0] perAddr,
  output logic [15:0]       perWdata,
  input  logic [15:0]       perRdata,
  output logic              busLock
);
  strobes_t strb;

  split_ctrl #(.BUS_CYCLES(BUS_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuSize(cpuSize),
    .strb(strb), .perSel(perSel), .busLock(busLock), .cpuReady(cpuReady)
  );

  split_datapath #(.ADDR_W(ADDR_W), .HALF_W(16)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .perRdata(perRdata),
    .perWrite(perWrite), .perAddr(perAddr), .perWdata(perWdata),
    .cpuRdata(cpuRdata)
  );
endmodule

// File: rtl/word_split_checker.sv
module word_split_checker #(
  parameter int ADDR_W     = 8,
  parameter int BUS_CYCLES = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReady,
  input logic              perSel,
  input logic              perWrite,
  input logic [ADDR_W-1:0] perAddr,
  input logic              busLock
);
  int selRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selRun <= 0;
    else       selRun <= perSel ? selRun + 1 : 0;
  end

  // R2, R4: a select run is one or two whole peripheral cycles
  a_r2_run_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(perSel) |-> (selRun == BUS_CYCLES || selRun == 2 * BUS_CYCLES));

  // R2: direction never changes inside a run
  a_r2_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (perSel && $past(perSel)) |-> $stable(perWrite));

  // R4: an address change inside a run is the locked move to the lower half
  a_r4_second_half: assert property (@(posedge clk) disable iff (!rstN)
    (perSel && $past(perSel) && perAddr != $past(perAddr)) |->
      (busLock && perAddr[1] && !$past(perAddr[1])));

  // R5: lock only during a peripheral cycle
  a_r5_lock_in_sel: assert property (@(posedge clk) disable iff (!rstN)
    busLock |-> perSel);

  // R8: ready is a single pulse outside any peripheral cycle
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> !perSel);
endmodule

bind word_split_bridge word_split_checker #(.ADDR_W(ADDR_W), .BUS_CYCLES(BUS_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReady(cpuReady), .perSel(perSel),
  .perWrite(perWrite), .perAddr(perAddr), .busLock(busLock)
);

// File: tb/word_split_bridge_bench.sv
module word_split_bridge_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [1:0]    cpuSize = 2'b01;
  logic [AW-1:0] cpuAddr = '0;
  logic [31:0]   cpuWdata = '0;
  logic          cpuReady, perSel, perWrite, busLock;
  logic [31:0]   cpuRdata;
  logic [AW-1:0] perAddr;
  logic [15:0]   perWdata, perRdata;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  word_split_bridge #(.ADDR_W(AW), .BUS_CYCLES(3)) u_word_split_bridge (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuSize(cpuSize), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuReady(cpuReady), .cpuRdata(cpuRdata), .perSel(perSel),
    .perWrite(perWrite), .perAddr(perAddr), .perWdata(perWdata),
    .perRdata(perRdata), .busLock(busLock)
  );

  // model register file
  logic [15:0] mem [0:(1<<(AW-1))-1];
  initial for (int i = 0; i < (1<<(AW-1)); i++) mem[i] = '0;
  always @(posedge clk) if (perSel && perWrite) mem[perAddr[AW-1:1]] <= perWdata;
  assign perRdata = mem[perAddr[AW-1:1]];

  // transaction monitor
  int selCnt, lockCnt, addrChg, rises;
  logic [AW-1:0] firstAddr, lastAddr;
  logic [15:0] firstWd, lastWd;
  logic prevSel = 1'b0;
  logic [AW-1:0] prevAddr = '0;
  logic prevWr = 1'b0;
  int wrChg;

  always @(negedge clk) begin
    if (perSel) begin
      if (!prevSel) begin rises++; firstAddr = perAddr; firstWd = perWdata; end
      else begin
        if (perAddr != prevAddr) addrChg++;
        if (perWrite != prevWr) wrChg++;
      end
      selCnt++;
      if (busLock) lockCnt++;
      lastAddr = perAddr; lastWd = perWdata;
    end else if (busLock) lockCnt++;
    prevSel = perSel; prevAddr = perAddr; prevWr = perWrite;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [1:0] sz, input logic [AW-1:0] addr,
                      input logic [31:0] wd, input bit disturb,
                      output logic [31:0] rd, output int lat);
    selCnt = 0; lockCnt = 0; addrChg = 0; rises = 0; wrChg = 0;
    cpuWrite = wr; cpuSize = sz; cpuAddr = addr; cpuWdata = wd; cpuReq = 1'b1;
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (disturb && lat == 2) begin cpuAddr = addr ^ 8'h40; cpuWdata = ~wd; end
      if (cpuReady || lat > 50) break;
    end
    rd = cpuRdata;
    cpuReq = 1'b0;
    @(negedge clk);
    check("R8", "ready pulse width", cpuReady, 0);
  endtask

  task automatic t_reset();
    check("R1", "ready after reset", cpuReady, 0);
    check("R1", "sel after reset", perSel, 0);
    check("R1", "lock after reset", busLock, 0);
  endtask

  task automatic t_word();
    logic [31:0] rd; int lat;
    xfer(1, 2'b01, 8'h10, 32'hA5A5BEEF, 0, rd, lat);
    check("R3", "word write latency", lat, 4);
    check("R3", "word sel clocks", selCnt, 3);
    check("R2", "word address changes", addrChg, 0);
    check("R5", "word lock clocks", lockCnt, 0);
    check("R6", "word write data", firstWd, 16'hBEEF);
    xfer(0, 2'b01, 8'h10, 32'h0, 0, rd, lat);
    check("R7", "word read data", rd, 32'h0000BEEF);
    check("R9", "word read latency", lat, 4);
  endtask

  task automatic t_byte();
    logic [31:0] rd; int lat;
    xfer(0, 2'b00, 8'h11, 32'h0, 0, rd, lat);
    check("R3", "byte latency", lat, 4);
    check("R3", "byte sel clocks", selCnt, 3);
    check("R3", "byte word address", firstAddr, 8'h10);
  endtask

  task automatic t_long();
    logic [31:0] rd; int lat;
    xfer(1, 2'b10, 8'h20, 32'h12345678, 0, rd, lat);
    check("R4", "long write latency", lat, 7);
    check("R4", "long sel clocks", selCnt, 6);
    check("R4", "long sel runs", rises, 1);
    check("R4", "first half address", firstAddr, 8'h20);
    check("R4", "second half address", lastAddr, 8'h22);
    check("R2", "direction stable", wrChg, 0);
    check("R5", "long lock clocks", lockCnt, 6);
    check("R6", "first half data", firstWd, 16'h1234);
    check("R6", "second half data", lastWd, 16'h5678);
    xfer(0, 2'b10, 8'h20, 32'h0, 0, rd, lat);
    check("R7", "long read data", rd, 32'h12345678);
    check("R9", "long read latency", lat, 7);
    check("R9", "long read lock clocks", lockCnt, 6);
    xfer(0, 2'b01, 8'h20, 32'h0, 0, rd, lat);
    check("R4", "upper half at offset 0", rd, 32'h1234);
    xfer(0, 2'b01, 8'h22, 32'h0, 0, rd, lat);
    check("R4", "lower half at offset 2", rd, 32'h5678);
  endtask

  task automatic t_disturb();
    logic [31:0] rd; int lat;
    xfer(1, 2'b10, 8'h30, 32'hCAFED00D, 1, rd, lat);
    check("R8", "second half addr ignores change", lastAddr, 8'h32);
    check("R8", "second half data ignores change", lastWd, 16'hD00D);
    xfer(0, 2'b10, 8'h70, 32'h0, 0, rd, lat);
    check("R8", "disturbed address untouched", rd, 32'h0);
    xfer(0, 2'b10, 8'h30, 32'h0, 0, rd, lat);
    check("R8", "captured long intact", rd, 32'hCAFED00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_word();
    t_byte();
    t_long();
    t_disturb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule